// File: doc/BRIEF.md
# Line Buffer Configuration Chooser

This block selects which of four line-buffer memory arrangements a vertical scaler should use. For one frame setup it works out how many full lines of luma and chroma the line buffer can hold in each arrangement. It then picks the first arrangement that holds enough lines for the requested vertical filter taps at the given downscale ratio. The pixel storage is not part of this block. Only the decision and the line (partition) counts are produced.

The host presents the frame parameters and pulses `start_i`. The block captures the parameters and runs one shared restoring divider many times. First it converts line lengths into memory words. Then, for each candidate arrangement, it turns plane sizes into partition counts. When the search ends it pulses `done_o` for one cycle and holds the chosen arrangement, the two partition counts and an error flag until the next search completes. A debug override skips the search and forces the largest arrangement that suits the chroma format.

Top module: `lbcfg_chooser`

## Requirements
- R1: The line length of each plane is the smaller of that plane's viewport width and the common output width. A result of zero counts as one. Luma and chroma are sized independently.
- R2: The depth code selects bits per component as follows: 0 gives 10, 1 gives 8, 2 gives 6 and 3 gives 12. A plane needs ceil(line × bits / 72) memory words per line.
- R3: The alpha plane needs ceil(luma line / 6) words per line. When alpha is enabled and the alpha partition count is below the luma count, the reported luma count is the alpha count.
- R4: Plane sizes in words are given as luma/chroma/alpha for each arrangement: arrangement 0 is 2752/2752/2752, arrangement 1 is 816/816/984, arrangement 2 is 1088/1088/1312 and arrangement 3 is 4448/1904/2752. A plane's partition count is its size divided by its words per line, rounded down.
- R5: Reported luma and chroma partition counts never exceed 64.
- R6: A plane fits if its tap count is at most partitions − ratio ceiling + 2 when the ratio ceiling is above 2, and at most its partition count otherwise. An arrangement fits only if both planes fit.
- R7: Without the override, candidates are tried in the order 1, 2, 3, 0, and arrangement 3 is skipped unless the 4:2:0 flag is set. The first candidate that fits is reported with `error_o` low.
- R8: If no candidate fits, arrangement 0 is reported with its partition counts and `error_o` high.
- R9: With the override bit set, arrangement 3 is reported for 4:2:0 input and arrangement 0 otherwise. Its partition counts are reported, and `error_o` is high exactly when it does not fit.
- R10: `done_o` is high for exactly one cycle per search. `cfg_o`, the partition counts and `error_o` change only in that cycle and are held otherwise.
- R11: The parameters are captured when `start_i` is sampled. A `start_i` or a change of the parameters while a search is running has no effect on that search.
- R12: After reset, `done_o` and `error_o` are low and `cfg_o`, `luma_parts_o` and `chroma_parts_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a search with the present parameters |
| luma_vp_width_i | input | LINE_W | Luma viewport width in pixels |
| chroma_vp_width_i | input | LINE_W | Chroma viewport width in pixels |
| out_width_i | input | LINE_W | Output rectangle width in pixels |
| depth_code_i | input | 2 | Stored component depth code |
| alpha_en_i | input | 1 | Alpha plane is stored |
| is_420_i | input | 1 | Source is 4:2:0 subsampled |
| vtaps_luma_i | input | TAP_W | Luma vertical tap count |
| vtaps_chroma_i | input | TAP_W | Chroma vertical tap count |
| vratio_ceil_luma_i | input | RATIO_W | Ceiling of luma vertical scale ratio |
| vratio_ceil_chroma_i | input | RATIO_W | Ceiling of chroma vertical scale ratio |
| use_max_i | input | 1 | Skip the search and force the largest arrangement |
| done_o | output | 1 | One-cycle completion pulse |
| error_o | output | 1 | Reported arrangement does not fit |
| cfg_o | output | 2 | Chosen arrangement number |
| luma_parts_o | output | PART_W | Luma partition count of the chosen arrangement |
| chroma_parts_o | output | PART_W | Chroma partition count of the chosen arrangement |

## Verification
A wrong words-per-line or quotient value stays hidden until the end of the search. It then shows up at `done_o` as a partition count or an arrangement number that differs from the model, typically a few hundred cycles after `start_i`. A wrong candidate sequence shows up as the wrong arrangement on the first frame whose cheaper options fail. A result register that is not held shows up on the very next clock as an output that moves while `done_o` is low. A stuck or doubled completion pulse shows up as a missing or extra `done_o` within one cycle of the expected end.

// File: rtl/lbcfg_pkg.sv
package lbcfg_pkg;

    typedef enum logic [1:0] {
        CFG0 = 2'd0,
        CFG1 = 2'd1,
        CFG2 = 2'd2,
        CFG3 = 2'd3
    } lb_cfg_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_WAIT   = 2'd2,
        ST_EVAL   = 2'd3
    } lb_state_e;

    localparam int SIZE_W = 13;

    function automatic logic [3:0] depth_bits(input logic [1:0] code);
        case (code)
            2'd0:    depth_bits = 4'd10;
            2'd1:    depth_bits = 4'd8;
            2'd2:    depth_bits = 4'd6;
            default: depth_bits = 4'd12;
        endcase
    endfunction

    function automatic logic [SIZE_W-1:0] luma_size(input lb_cfg_e c);
        case (c)
            CFG1:    luma_size = 13'd816;
            CFG2:    luma_size = 13'd1088;
            CFG3:    luma_size = 13'd4448;
            default: luma_size = 13'd2752;
        endcase
    endfunction

    function automatic logic [SIZE_W-1:0] chroma_size(input lb_cfg_e c);
        case (c)
            CFG1:    chroma_size = 13'd816;
            CFG2:    chroma_size = 13'd1088;
            CFG3:    chroma_size = 13'd1904;
            default: chroma_size = 13'd2752;
        endcase
    endfunction

    function automatic logic [SIZE_W-1:0] alpha_size(input lb_cfg_e c);
        case (c)
            CFG1:    alpha_size = 13'd984;
            CFG2:    alpha_size = 13'd1312;
            default: alpha_size = 13'd2752;
        endcase
    endfunction

    function automatic lb_cfg_e next_cfg(input lb_cfg_e c, input logic is_420);
        case (c)
            CFG1:    next_cfg = CFG2;
            CFG2:    next_cfg = is_420 ? CFG3 : CFG0;
            default: next_cfg = CFG0;
        endcase
    endfunction

endpackage

// File: rtl/lbcfg_divider.sv
module lbcfg_divider #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         valid_o,
    output logic [W-1:0] quotient_o
);
    localparam int CNT_W = $clog2(W + 1);

    typedef struct packed {
        logic             busy;
        logic             valid;
        logic [CNT_W-1:0] cnt;
        logic [W-1:0]     rem;
        logic [W-1:0]     quo;
        logic [W-1:0]     dvs;
        logic [W-1:0]     dvd;
    } div_state_t;

    div_state_t s_d, s_q;
    logic [W:0] shifted;
    logic       take;

    always_comb begin
        s_d       = s_q;
        s_d.valid = 1'b0;
        shifted   = {s_q.rem, s_q.quo[W-1]};
        take      = (shifted >= {1'b0, s_q.dvs});
        if (s_q.busy) begin
            s_d.rem = take ? W'(shifted - {1'b0, s_q.dvs}) : shifted[W-1:0];
            s_d.quo = {s_q.quo[W-2:0], take};
            s_d.cnt = s_q.cnt - 1'b1;
            if (s_q.cnt == CNT_W'(1)) begin
                s_d.busy  = 1'b0;
                s_d.valid = 1'b1;
            end
        end else if (go_i) begin
            s_d.busy = 1'b1;
            s_d.cnt  = CNT_W'(W);
            s_d.rem  = '0;
            s_d.quo  = dividend_i;
            s_d.dvd  = dividend_i;
            s_d.dvs  = divisor_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign valid_o    = s_q.valid;
    assign quotient_o = s_q.quo;

    // R4
    div_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.valid |-> ((2*W)'(s_q.quo) * (2*W)'(s_q.dvs) + (2*W)'(s_q.rem) == (2*W)'(s_q.dvd)
                       && s_q.rem < s_q.dvs));

    // R11
    div_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> !go_i);

endmodule

// File: rtl/lbcfg_fit.sv
module lbcfg_fit #(
    parameter int DIV_W    = 18,
    parameter int TAP_W    = 4,
    parameter int RATIO_W  = 4,
    parameter int PART_CAP = 64,
    parameter int PART_W   = 7
) (
    input  logic [DIV_W-1:0]   q_luma_i,
    input  logic [DIV_W-1:0]   q_chroma_i,
    input  logic [DIV_W-1:0]   q_alpha_i,
    input  logic               alpha_en_i,
    input  logic [TAP_W-1:0]   taps_luma_i,
    input  logic [TAP_W-1:0]   taps_chroma_i,
    input  logic [RATIO_W-1:0] ratio_luma_i,
    input  logic [RATIO_W-1:0] ratio_chroma_i,
    output logic [PART_W-1:0]  parts_luma_o,
    output logic [PART_W-1:0]  parts_chroma_o,
    output logic               fit_o
);
    localparam int CW = PART_W + TAP_W + RATIO_W;
    localparam logic [DIV_W-1:0]  CAP_D = DIV_W'(PART_CAP);
    localparam logic [PART_W-1:0] CAP_P = PART_W'(PART_CAP);

    logic [DIV_W-1:0]   raw   [2];
    logic [TAP_W-1:0]   taps  [2];
    logic [RATIO_W-1:0] ratio [2];
    logic [PART_W-1:0]  capped[2];
    logic [1:0]         ok;

    always_comb begin
        raw[0]   = (alpha_en_i && (q_alpha_i < q_luma_i)) ? q_alpha_i : q_luma_i;
        raw[1]   = q_chroma_i;
        taps[0]  = taps_luma_i;
        taps[1]  = taps_chroma_i;
        ratio[0] = ratio_luma_i;
        ratio[1] = ratio_chroma_i;
    end

    for (genvar g = 0; g < 2; g++) begin : g_plane
        always_comb begin
            capped[g] = (raw[g] > CAP_D) ? CAP_P : raw[g][PART_W-1:0];
            if (ratio[g] > RATIO_W'(2))
                ok[g] = (CW'(taps[g]) + CW'(ratio[g])) <= (CW'(capped[g]) + CW'(2));
            else
                ok[g] = CW'(taps[g]) <= CW'(capped[g]);
        end
    end

    assign parts_luma_o   = capped[0];
    assign parts_chroma_o = capped[1];
    assign fit_o          = &ok;

endmodule

// File: rtl/lbcfg_chooser.sv
module lbcfg_chooser #(
    parameter int LINE_W   = 14,
    parameter int TAP_W    = 4,
    parameter int RATIO_W  = 4,
    parameter int PART_CAP = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [LINE_W-1:0]     luma_vp_width_i,
    input  logic [LINE_W-1:0]     chroma_vp_width_i,
    input  logic [LINE_W-1:0]     out_width_i,
    input  logic [1:0]            depth_code_i,
    input  logic                  alpha_en_i,
    input  logic                  is_420_i,
    input  logic [TAP_W-1:0]      vtaps_luma_i,
    input  logic [TAP_W-1:0]      vtaps_chroma_i,
    input  logic [RATIO_W-1:0]    vratio_ceil_luma_i,
    input  logic [RATIO_W-1:0]    vratio_ceil_chroma_i,
    input  logic                  use_max_i,
    output logic                  done_o,
    output logic                  error_o,
    output logic [1:0]            cfg_o,
    output logic [$clog2(PART_CAP+1)-1:0] luma_parts_o,
    output logic [$clog2(PART_CAP+1)-1:0] chroma_parts_o
);
    import lbcfg_pkg::*;

    localparam int PART_W = $clog2(PART_CAP + 1);
    localparam int DIV_W  = (LINE_W + 4 > SIZE_W) ? LINE_W + 4 : SIZE_W;

    typedef struct packed {
        lb_state_e          st;
        logic [2:0]         op;
        lb_cfg_e            cfg;
        logic [LINE_W-1:0]  line_y;
        logic [LINE_W-1:0]  line_c;
        logic [3:0]         bits;
        logic               alpha_en;
        logic               is_420;
        logic               use_max;
        logic [TAP_W-1:0]   taps_y;
        logic [TAP_W-1:0]   taps_c;
        logic [RATIO_W-1:0] rat_y;
        logic [RATIO_W-1:0] rat_c;
        logic [DIV_W-1:0]   words_y;
        logic [DIV_W-1:0]   words_c;
        logic [DIV_W-1:0]   words_a;
        logic [DIV_W-1:0]   q_y;
        logic [DIV_W-1:0]   q_c;
        logic [DIV_W-1:0]   q_a;
        lb_cfg_e            res_cfg;
        logic [PART_W-1:0]  res_py;
        logic [PART_W-1:0]  res_pc;
        logic               res_err;
        logic               done;
    } chooser_state_t;

    chooser_state_t s_d, s_q;

    logic              div_go;
    logic [DIV_W-1:0]  div_num;
    logic [DIV_W-1:0]  div_den;
    logic              div_valid;
    logic [DIV_W-1:0]  div_quo;
    logic [PART_W-1:0] fit_py;
    logic [PART_W-1:0] fit_pc;
    logic              fit_ok;
    logic              last_cand;

    function automatic logic [LINE_W-1:0] line_len(input logic [LINE_W-1:0] vp,
                                                   input logic [LINE_W-1:0] ow);
        logic [LINE_W-1:0] m;
        m = (vp < ow) ? vp : ow;
        return (m == '0) ? LINE_W'(1) : m;
    endfunction

    lbcfg_divider #(.W(DIV_W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (div_go),
        .dividend_i (div_num),
        .divisor_i  (div_den),
        .valid_o    (div_valid),
        .quotient_o (div_quo)
    );

    lbcfg_fit #(
        .DIV_W    (DIV_W),
        .TAP_W    (TAP_W),
        .RATIO_W  (RATIO_W),
        .PART_CAP (PART_CAP),
        .PART_W   (PART_W)
    ) u_fit (
        .q_luma_i       (s_q.q_y),
        .q_chroma_i     (s_q.q_c),
        .q_alpha_i      (s_q.q_a),
        .alpha_en_i     (s_q.alpha_en),
        .taps_luma_i    (s_q.taps_y),
        .taps_chroma_i  (s_q.taps_c),
        .ratio_luma_i   (s_q.rat_y),
        .ratio_chroma_i (s_q.rat_c),
        .parts_luma_o   (fit_py),
        .parts_chroma_o (fit_pc),
        .fit_o          (fit_ok)
    );

    // Operand selection for the shared divider, by operation index.
    always_comb begin
        case (s_q.op)
            3'd0: begin
                div_num = DIV_W'(s_q.line_y) * DIV_W'(s_q.bits) + DIV_W'(71);
                div_den = DIV_W'(72);
            end
            3'd1: begin
                div_num = DIV_W'(s_q.line_c) * DIV_W'(s_q.bits) + DIV_W'(71);
                div_den = DIV_W'(72);
            end
            3'd2: begin
                div_num = DIV_W'(s_q.line_y) + DIV_W'(5);
                div_den = DIV_W'(6);
            end
            3'd3: begin
                div_num = DIV_W'(luma_size(s_q.cfg));
                div_den = s_q.words_y;
            end
            3'd4: begin
                div_num = DIV_W'(chroma_size(s_q.cfg));
                div_den = s_q.words_c;
            end
            default: begin
                div_num = DIV_W'(alpha_size(s_q.cfg));
                div_den = s_q.words_a;
            end
        endcase
    end

    always_comb begin
        s_d       = s_q;
        s_d.done  = 1'b0;
        div_go    = 1'b0;
        last_cand = s_q.use_max || (s_q.cfg == CFG0);
        case (s_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    s_d.line_y   = line_len(luma_vp_width_i, out_width_i);
                    s_d.line_c   = line_len(chroma_vp_width_i, out_width_i);
                    s_d.bits     = depth_bits(depth_code_i);
                    s_d.alpha_en = alpha_en_i;
                    s_d.is_420   = is_420_i;
                    s_d.use_max  = use_max_i;
                    s_d.taps_y   = vtaps_luma_i;
                    s_d.taps_c   = vtaps_chroma_i;
                    s_d.rat_y    = vratio_ceil_luma_i;
                    s_d.rat_c    = vratio_ceil_chroma_i;
                    s_d.op       = 3'd0;
                    s_d.cfg      = use_max_i ? (is_420_i ? CFG3 : CFG0) : CFG1;
                    s_d.st       = ST_LAUNCH;
                end
            end
            ST_LAUNCH: begin
                div_go = 1'b1;
                s_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (div_valid) begin
                    case (s_q.op)
                        3'd0:    s_d.words_y = div_quo;
                        3'd1:    s_d.words_c = div_quo;
                        3'd2:    s_d.words_a = div_quo;
                        3'd3:    s_d.q_y     = div_quo;
                        3'd4:    s_d.q_c     = div_quo;
                        default: s_d.q_a     = div_quo;
                    endcase
                    if (s_q.op == 3'd5) begin
                        s_d.st = ST_EVAL;
                    end else begin
                        s_d.op = s_q.op + 3'd1;
                        s_d.st = ST_LAUNCH;
                    end
                end
            end
            default: begin
                if (fit_ok || last_cand) begin
                    s_d.res_cfg = s_q.cfg;
                    s_d.res_py  = fit_py;
                    s_d.res_pc  = fit_pc;
                    s_d.res_err = !fit_ok;
                    s_d.done    = 1'b1;
                    s_d.st      = ST_IDLE;
                end else begin
                    s_d.cfg = next_cfg(s_q.cfg, s_q.is_420);
                    s_d.op  = 3'd3;
                    s_d.st  = ST_LAUNCH;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign done_o         = s_q.done;
    assign error_o        = s_q.res_err;
    assign cfg_o          = s_q.res_cfg;
    assign luma_parts_o   = s_q.res_py;
    assign chroma_parts_o = s_q.res_pc;

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(cfg_o) && $stable(luma_parts_o)
                     && $stable(chroma_parts_o) && $stable(error_o)));

    // R5
    part_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (luma_parts_o <= PART_W'(PART_CAP)) && (chroma_parts_o <= PART_W'(PART_CAP)));

    // R7
    cfg3_only_420_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cfg_o == 2'd3) |-> s_q.is_420);

    // R8
    error_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && error_o) |-> (cfg_o == 2'd0 || s_q.use_max));

    // R11
    busy_ignores_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st != ST_IDLE && s_q.st != ST_EVAL) |=> $stable(s_q.line_y) && $stable(s_q.taps_y));

endmodule

// File: tb/lbcfg_chooser_test.sv
module lbcfg_chooser_test;

    localparam int LINE_W = 14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [LINE_W-1:0] vp_y = '0, vp_c = '0, ow = '0;
    logic [1:0]        dcode = '0;
    logic              alpha = 1'b0, f420 = 1'b0, umax = 1'b0;
    logic [3:0]        t_y = '0, t_c = '0, r_y = '0, r_c = '0;
    logic              done, err;
    logic [1:0]        cfg;
    logic [6:0]        py, pc;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int wait_cnt = 0;
    bit pending = 0;
    int exp_cfg, exp_py, exp_pc, exp_err;
    int held_cfg = 0, held_py = 0, held_pc = 0, held_err = 0;
    string cur_req = "R12";

    always #10 clk = ~clk;

    lbcfg_chooser uut (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .luma_vp_width_i(vp_y), .chroma_vp_width_i(vp_c), .out_width_i(ow),
        .depth_code_i(dcode), .alpha_en_i(alpha), .is_420_i(f420),
        .vtaps_luma_i(t_y), .vtaps_chroma_i(t_c),
        .vratio_ceil_luma_i(r_y), .vratio_ceil_chroma_i(r_c),
        .use_max_i(umax), .done_o(done), .error_o(err), .cfg_o(cfg),
        .luma_parts_o(py), .chroma_parts_o(pc)
    );

    function automatic int bits_of(int code);
        case (code)
            0: return 10;
            1: return 8;
            2: return 6;
            default: return 12;
        endcase
    endfunction

    function automatic bit plane_fits(int taps, int r, int p);
        if (r > 2) return taps <= p - r + 2;
        return taps <= p;
    endfunction

    task automatic model(output int o_cfg, output int o_py, output int o_pc, output int o_err);
        int ly, lc, b, wy, wc, wa, n;
        int cands[4];
        ly = (vp_y < ow) ? int'(vp_y) : int'(ow);
        lc = (vp_c < ow) ? int'(vp_c) : int'(ow);
        if (ly == 0) ly = 1;
        if (lc == 0) lc = 1;
        b  = bits_of(int'(dcode));
        wy = (ly * b + 71) / 72;
        wc = (lc * b + 71) / 72;
        wa = (ly + 5) / 6;
        n = 0;
        if (umax) begin
            cands[0] = f420 ? 3 : 0; n = 1;
        end else begin
            cands[n++] = 1; cands[n++] = 2;
            if (f420) cands[n++] = 3;
            cands[n++] = 0;
        end
        for (int i = 0; i < n; i++) begin
            int sy, sc, sa, qy, qc, qa;
            bit ok;
            case (cands[i])
                1: begin sy = 816;  sc = 816;  sa = 984;  end
                2: begin sy = 1088; sc = 1088; sa = 1312; end
                3: begin sy = 4448; sc = 1904; sa = 2752; end
                default: begin sy = 2752; sc = 2752; sa = 2752; end
            endcase
            qy = sy / wy; qc = sc / wc; qa = sa / wa;
            if (alpha && qa < qy) qy = qa;
            if (qy > 64) qy = 64;
            if (qc > 64) qc = 64;
            ok = plane_fits(int'(t_y), int'(r_y), qy) && plane_fits(int'(t_c), int'(r_c), qc);
            if (ok || i == n - 1) begin
                o_cfg = cands[i]; o_py = qy; o_pc = qc; o_err = ok ? 0 : 1;
                return;
            end
        end
    endtask

    // Per-clock comparison against the behavioural model.
    always @(negedge clk) begin
        if (rst_n) begin
            cycles++;
            if (done) begin
                checks++;
                if (!pending) begin
                    errors++;
                    $display("FAIL %s: unexpected done pulse (actual done=1, expected 0)", cur_req);
                end else if (int'(cfg) != exp_cfg || int'(py) != exp_py
                             || int'(pc) != exp_pc || int'(err) != exp_err) begin
                    errors++;
                    $display("FAIL %s: actual cfg=%0d py=%0d pc=%0d err=%0d expected cfg=%0d py=%0d pc=%0d err=%0d",
                             cur_req, cfg, py, pc, err, exp_cfg, exp_py, exp_pc, exp_err);
                end
                pending  = 0;
                held_cfg = int'(cfg); held_py = int'(py);
                held_pc  = int'(pc);  held_err = int'(err);
            end else begin
                checks++;
                // R10: results held while done is low
                if (int'(cfg) != held_cfg || int'(py) != held_py
                    || int'(pc) != held_pc || int'(err) != held_err) begin
                    errors++;
                    $display("FAIL R10: outputs moved without done: actual cfg=%0d py=%0d pc=%0d err=%0d expected cfg=%0d py=%0d pc=%0d err=%0d",
                             cfg, py, pc, err, held_cfg, held_py, held_pc, held_err);
                    held_cfg = int'(cfg); held_py = int'(py);
                    held_pc  = int'(pc);  held_err = int'(err);
                end
                if (pending) begin
                    wait_cnt++;
                    if (wait_cnt > 2000) begin
                        errors++;
                        $display("FAIL %s: no done (actual timeout, expected done)", cur_req);
                        pending = 0;
                    end
                end
            end
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    task automatic run(input string req, input int wy_, input int wc_, input int ow_,
                       input int dc, input bit al, input bit is420, input bit um,
                       input int ty, input int tc, input int ry, input int rc);
        @(negedge clk);
        cur_req = req;
        vp_y = LINE_W'(wy_); vp_c = LINE_W'(wc_); ow = LINE_W'(ow_);
        dcode = 2'(dc); alpha = al; f420 = is420; umax = um;
        t_y = 4'(ty); t_c = 4'(tc); r_y = 4'(ry); r_c = 4'(rc);
        model(exp_cfg, exp_py, exp_pc, exp_err);
        start = 1'b1; pending = 1; wait_cnt = 0;
        @(negedge clk);
        start = 1'b0;
        while (pending) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        // R12: reset state
        if (done !== 1'b0 || err !== 1'b0 || cfg !== 2'd0 || py !== 7'd0 || pc !== 7'd0) begin
            errors++;
            $display("FAIL R12: actual done=%0d err=%0d cfg=%0d py=%0d pc=%0d expected all 0",
                     done, err, cfg, py, pc);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run("R7",  1920, 960, 1920, 1, 0, 0, 0, 4, 4, 1, 1);   // cfg1 short, cfg2 fits
        run("R4",  640, 640, 1920, 1, 0, 0, 0, 4, 4, 1, 1);    // cfg1 fits
        run("R7",  3840, 1920, 3840, 3, 0, 1, 0, 4, 4, 1, 1);  // 4:2:0 reaches cfg3
        run("R7",  3840, 3840, 3840, 3, 0, 0, 0, 4, 4, 1, 1);  // non-4:2:0 skips cfg3
        run("R8",  8000, 8000, 8000, 3, 0, 0, 0, 6, 6, 1, 1);  // nothing fits
        run("R1",  0, 0, 1920, 0, 0, 0, 0, 2, 2, 1, 1);        // zero width -> one
        run("R5",  1, 1, 1, 3, 0, 0, 0, 8, 8, 1, 1);           // cap at 64
        run("R3",  1920, 1920, 1920, 2, 1, 0, 0, 4, 4, 1, 1);  // alpha limits luma
        run("R3",  1920, 1920, 1920, 2, 0, 0, 0, 4, 4, 1, 1);  // same without alpha
        run("R6",  640, 640, 640, 1, 0, 0, 0, 8, 8, 4, 1);     // ratio 4 fits cfg1
        run("R6",  640, 640, 640, 1, 0, 0, 0, 8, 8, 6, 6);     // ratio 6 needs cfg2
        run("R6",  640, 640, 640, 1, 0, 0, 0, 8, 2, 2, 2);     // ratio 2 plain rule
        run("R2",  3000, 1500, 2000, 0, 0, 0, 0, 3, 3, 1, 1);  // 10 bits, out narrower
        run("R2",  5000, 2500, 5000, 2, 0, 1, 0, 5, 5, 3, 3);  // 6 bits 4:2:0
        run("R1",  4000, 100, 2500, 1, 0, 0, 0, 5, 5, 1, 1);   // per-plane min
        run("R9",  640, 640, 640, 1, 0, 1, 1, 2, 2, 1, 1);     // forced cfg3
        run("R9",  640, 640, 640, 1, 0, 0, 1, 2, 2, 1, 1);     // forced cfg0
        run("R9",  8000, 8000, 8000, 3, 1, 1, 1, 8, 8, 3, 3);  // forced, fails

        // R11: second start and new parameters during a search are ignored
        @(negedge clk);
        cur_req = "R11";
        vp_y = 14'd1920; vp_c = 14'd960; ow = 14'd1920; dcode = 2'd1;
        alpha = 0; f420 = 0; umax = 0; t_y = 4'd4; t_c = 4'd4; r_y = 4'd1; r_c = 4'd1;
        model(exp_cfg, exp_py, exp_pc, exp_err);
        start = 1'b1; pending = 1; wait_cnt = 0;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        vp_y = 14'd1; ow = 14'd1; t_y = 4'd15; umax = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (pending) @(negedge clk);
        repeat (5) @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule